// File: doc/BRIEF.md
# PLL Clock Source Switchover Sequencer

This block decides which of two clocks a video decoder runs on: the crystal clock taken directly, or a clock made by an external frequency synthesizer. It holds the synthesizer settings: reference divider, integer multiplier, 16-bit fractional multiplier and output divider. Software writes the settings and then sets an enable bit. The block then waits for the synthesizer's lock signal and moves the clock select over only once that lock has been qualified.

Lock is brought into the local clock domain through two flops. It must then stay high for a programmable run of cycles before it counts. A programmable timeout, counted in prescaled ticks, ends the wait with an error while the clock stays on the crystal. A zero integer multiplier powers the synthesizer down and keeps the crystal selected. A loss of lock while the synthesized clock is in use returns the select to the crystal, raises a sticky flag and starts the wait again. Any settings write sends the select back to the crystal first, so the synthesized clock is never in use while its settings change.

Top module: `pll_switch_seq`

## Requirements
- R1: After reset the select is on the crystal (clk_sel_pll=0), and status reads 0. The settings reset to: reference divider 1, integer 0 (so pll_pwrdn=1), fraction 0, output divider 0, timeout all ones, qualify length 4.
- R2: Register addresses are 0 control (bit0 enable), 1 status, 2 reference divider (6 bits), 3 integer (8 bits), 4 fraction (16 bits), 5 output divider (4 bits), 6 timeout (16 bits) and 7 qualify length (8 bits). Each field reads back zero-extended to 16 bits and drives the matching pll_* output.
- R3: While the integer field is zero, pll_pwrdn is 1 and the select stays on the crystal, whatever the enable bit and the lock input do.
- R4: A write to any address other than status sets the select to the crystal on the same clock edge. It then restarts the sequence: one cycle idle, one cycle programming, then the lock wait.
- R5: Status bit0 is the qualified lock, and it requires lock_in to come through two synchronizer flops. The synchronized lock must then stay high for qualify length Q plus one consecutive cycles. If the wait is under way and lock_in rises before edge E, the select moves to the synthesized clock at edge E+Q+2.
- R6: The lock qualification is cleared at each restart. If lock_in is steady high across a settings write at edge C, the select moves to the synthesized clock no earlier than edge C+Q+3, and exactly at that edge.
- R7: The lock wait uses a timeout counter. If no qualified lock arrives within (L+1)·2^TICK_W cycles, status bit2 (timeout error) is set and the select stays on the crystal, even if lock arrives later. The block leaves this state only through a settings write. With TICK_W=0, a settings write at edge C sets the error at edge C+L+3.
- R8: While the synthesized clock is selected, a low synchronized lock returns the select to the crystal, sets sticky status bit1 (loss of lock) and restarts the lock wait. lock_in falling before edge F drops the select at edge F+2.
- R9: Status bits 1 and 2 are cleared only by writing 1 to them at address 1. Writing 0 to them leaves them unchanged, and a status write does not move the select. Status bit3 mirrors clk_sel_pll.
- R10: Clearing the enable bit returns the select to the crystal, and it stays there while lock remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| lock_in | input | 1 | Asynchronous lock indication from the synthesizer |
| clk_sel_pll | output | 1 | Registered clock select: 1 = synthesized clock, 0 = crystal |
| pll_pwrdn | output | 1 | Synthesizer power-down (integer field is zero) |
| pll_refdiv | output | 6 | Reference divider setting |
| pll_mult_int | output | 8 | Integer multiplier setting |
| pll_mult_frac | output | 16 | Fractional multiplier setting |
| pll_outdiv | output | 4 | Output divider setting |

## Verification
Two situations are the hardest to reach from the ports. In the first, the lock input is already steady high when the settings are rewritten, so a stale lock could wrongly carry the select straight back to the synthesized clock. In the second, the timeout fires, which at the default tick prescale would take millions of cycles. The bench holds lock high across settings writes and counts edges to the exact switch cycle. It builds the block with no tick prescale and a small timeout limit, so the expiry edge can be checked. It also drops lock while the synthesized clock is in use and follows the sticky flag through writes of 0 and of 1.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_REFDIV = 3'd2;
  localparam logic [ADDR_W-1:0] A_INT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FRAC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_OUTDIV = 3'd5;
  localparam logic [ADDR_W-1:0] A_TMO    = 3'd6;
  localparam logic [ADDR_W-1:0] A_QUAL   = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE_XTAL,
    ST_PROGRAM,
    ST_WAIT_LOCK,
    ST_PLL_ACTIVE,
    ST_POWER_DOWN,
    ST_ERROR
  } seq_state_t;

  // Lock run is accepted once the counted cycles reach the qualify length.
  function automatic logic qual_met(input int unsigned run, input int unsigned need);
    return run >= need;
  endfunction

  // Timeout fires on the tick where the tick count equals the limit.
  function automatic logic tmo_hit(input int unsigned ticks, input int unsigned limit);
    return ticks == limit;
  endfunction

endpackage

// File: rtl/pll_cfg_regs.sv
`timescale 1ns/1ps
module pll_cfg_regs
  import pll_seq_pkg::*;
#(
  parameter int REF_W  = 6,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int POST_W = 4,
  parameter int TMO_W  = 16,
  parameter int QUAL_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lock_ok,
  input  logic              sel_pll,
  input  logic              lol_set,
  input  logic              lol_clr,
  input  logic              tmo_set,
  input  logic              tmo_clr,
  output logic              enable,
  output logic [REF_W-1:0]  refdiv,
  output logic [INT_W-1:0]  mult_int,
  output logic [FRAC_W-1:0] mult_frac,
  output logic [POST_W-1:0] outdiv,
  output logic [TMO_W-1:0]  tmo_limit,
  output logic [QUAL_W-1:0] qual_len,
  output logic              lol_flag,
  output logic              tmo_flag
);

  localparam logic [REF_W-1:0]  REF_RST  = REF_W'(1);
  localparam logic [QUAL_W-1:0] QUAL_RST = QUAL_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      refdiv    <= REF_RST;
      mult_int  <= '0;
      mult_frac <= '0;
      outdiv    <= '0;
      tmo_limit <= '1;
      qual_len  <= QUAL_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   enable    <= wr_data[0];
        A_REFDIV: refdiv    <= wr_data[REF_W-1:0];
        A_INT:    mult_int  <= wr_data[INT_W-1:0];
        A_FRAC:   mult_frac <= wr_data[FRAC_W-1:0];
        A_OUTDIV: outdiv    <= wr_data[POST_W-1:0];
        A_TMO:    tmo_limit <= wr_data[TMO_W-1:0];
        A_QUAL:   qual_len  <= wr_data[QUAL_W-1:0];
        default:  ;
      endcase
    end
  end

  // Sticky flags: a set in the same cycle wins over a clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lol_flag <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      if (lol_set)      lol_flag <= 1'b1;
      else if (lol_clr) lol_flag <= 1'b0;
      if (tmo_set)      tmo_flag <= 1'b1;
      else if (tmo_clr) tmo_flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = DATA_W'(enable);
      A_STATUS: rd_data = DATA_W'({sel_pll, tmo_flag, lol_flag, lock_ok});
      A_REFDIV: rd_data = DATA_W'(refdiv);
      A_INT:    rd_data = DATA_W'(mult_int);
      A_FRAC:   rd_data = DATA_W'(mult_frac);
      A_OUTDIV: rd_data = DATA_W'(outdiv);
      A_TMO:    rd_data = DATA_W'(tmo_limit);
      default:  rd_data = DATA_W'(qual_len);
    endcase
  end

endmodule

// File: rtl/pll_lock_qual.sv
`timescale 1ns/1ps
module pll_lock_qual
  import pll_seq_pkg::*;
#(
  parameter int QUAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_raw,
  input  logic              clr,
  input  logic [QUAL_W-1:0] qual_len,
  output logic              lock_sync,
  output logic              lock_ok
);

  logic              meta_q;
  logic [QUAL_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q    <= 1'b0;
      lock_sync <= 1'b0;
    end else begin
      meta_q    <= lock_raw;
      lock_sync <= meta_q;
    end
  end

  // Counts consecutive synchronized-high cycles, saturating at all ones.
  always_ff @(posedge clk) begin
    if (!rst_n || clr || !lock_sync) begin
      run_q <= '0;
    end else if (run_q != '1) begin
      run_q <= run_q + QUAL_W'(1);
    end
  end

  assign lock_ok = lock_sync && qual_met(32'(run_q), 32'(qual_len));

endmodule

// File: rtl/pll_seq_fsm.sv
`timescale 1ns/1ps
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int TMO_W  = 16,
  parameter int TICK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bypass,
  input  logic             cfg_wr,
  input  logic             lock_sync,
  input  logic             lock_ok,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             qual_clr,
  output logic             sel_pll,
  output logic             lol_set,
  output logic             tmo_set
);

  seq_state_t       st, nxt;
  logic             tick;
  logic             expire;
  logic [TMO_W-1:0] tmo_cnt;

  generate
    if (TICK_W == 0) begin : g_notick
      assign tick = 1'b1;
    end else begin : g_tick
      logic [TICK_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n || st != ST_WAIT_LOCK) pre_q <= '0;
        else                              pre_q <= pre_q + TICK_W'(1);
      end
      assign tick = &pre_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || st != ST_WAIT_LOCK) tmo_cnt <= '0;
    else if (tick)                    tmo_cnt <= tmo_cnt + TMO_W'(1);
  end

  assign expire = tick && tmo_hit(32'(tmo_cnt), 32'(tmo_limit));

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE_XTAL:  if (bypass) nxt = ST_POWER_DOWN;
                     else if (enable) nxt = ST_PROGRAM;
      ST_PROGRAM:    nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK:  if (lock_ok) nxt = ST_PLL_ACTIVE;
                     else if (expire) nxt = ST_ERROR;
      ST_PLL_ACTIVE: if (!lock_sync) nxt = ST_PROGRAM;
      ST_POWER_DOWN: if (!bypass) nxt = ST_IDLE_XTAL;
      ST_ERROR:      nxt = ST_ERROR;
      default:       nxt = ST_IDLE_XTAL;
    endcase
    if (cfg_wr) nxt = ST_IDLE_XTAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE_XTAL;
      sel_pll <= 1'b0;
    end else begin
      st      <= nxt;
      sel_pll <= (nxt == ST_PLL_ACTIVE);
    end
  end

  assign qual_clr = (st == ST_PROGRAM);
  assign lol_set  = (st == ST_PLL_ACTIVE) && !lock_sync;
  assign tmo_set  = (st == ST_WAIT_LOCK) && !lock_ok && expire;

endmodule

// File: rtl/pll_switch_seq.sv
`timescale 1ns/1ps
module pll_switch_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_W  = 6,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int POST_W = 4,
  parameter int TMO_W  = 16,
  parameter int QUAL_W = 8,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [15:0]       rd_data,
  input  logic              lock_in,
  output logic              clk_sel_pll,
  output logic              pll_pwrdn,
  output logic [REF_W-1:0]  pll_refdiv,
  output logic [INT_W-1:0]  pll_mult_int,
  output logic [FRAC_W-1:0] pll_mult_frac,
  output logic [POST_W-1:0] pll_outdiv
);

  localparam int DATA_W = 16;

  logic              stat_wr, cfg_wr, lol_clr, tmo_clr;
  logic              enable, bypass;
  logic              lock_sync, lock_ok, qual_clr;
  logic              lol_set, tmo_set, lol_flag, tmo_flag;
  logic [TMO_W-1:0]  tmo_limit;
  logic [QUAL_W-1:0] qual_len;

  assign stat_wr   = wr_en && (wr_addr == A_STATUS);
  assign cfg_wr    = wr_en && !stat_wr;
  assign lol_clr   = stat_wr && wr_data[1];
  assign tmo_clr   = stat_wr && wr_data[2];
  assign bypass    = (pll_mult_int == '0);
  assign pll_pwrdn = bypass;

  pll_cfg_regs #(
    .REF_W(REF_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .POST_W(POST_W),
    .TMO_W(TMO_W), .QUAL_W(QUAL_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lock_ok(lock_ok), .sel_pll(clk_sel_pll),
    .lol_set(lol_set), .lol_clr(lol_clr),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr),
    .enable(enable), .refdiv(pll_refdiv), .mult_int(pll_mult_int),
    .mult_frac(pll_mult_frac), .outdiv(pll_outdiv),
    .tmo_limit(tmo_limit), .qual_len(qual_len),
    .lol_flag(lol_flag), .tmo_flag(tmo_flag)
  );

  pll_lock_qual #(.QUAL_W(QUAL_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_in), .clr(qual_clr),
    .qual_len(qual_len), .lock_sync(lock_sync), .lock_ok(lock_ok)
  );

  pll_seq_fsm #(.TMO_W(TMO_W), .TICK_W(TICK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bypass(bypass),
    .cfg_wr(cfg_wr), .lock_sync(lock_sync), .lock_ok(lock_ok),
    .tmo_limit(tmo_limit), .qual_clr(qual_clr), .sel_pll(clk_sel_pll),
    .lol_set(lol_set), .tmo_set(tmo_set)
  );

endmodule

// File: rtl/pll_switch_seq_chk.sv
`timescale 1ns/1ps
module pll_switch_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic lock_ok,
  input logic lock_sync,
  input logic clk_sel_pll,
  input logic pll_pwrdn,
  input logic lol_flag,
  input logic lol_clr,
  input logic tmo_flag
);

  AST_PWRDN_ON_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !clk_sel_pll); // R3

  AST_WRITE_DROPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !clk_sel_pll); // R4

  AST_SEL_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_pll) |-> $past(lock_ok)); // R6

  AST_TMO_ON_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> !clk_sel_pll); // R7

  AST_SEL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_pll |-> $past(lock_sync)); // R8

  AST_LOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lol_flag && !lol_clr) |=> lol_flag); // R9

endmodule

bind pll_switch_seq pll_switch_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .lock_ok(lock_ok),
  .lock_sync(lock_sync), .clk_sel_pll(clk_sel_pll), .pll_pwrdn(pll_pwrdn),
  .lol_flag(lol_flag), .lol_clr(lol_clr), .tmo_flag(tmo_flag)
);

// File: tb/pll_switch_seq_bench.sv
`timescale 1ns/1ps
module pll_switch_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        lock_in = 1'b0;
  logic        clk_sel_pll, pll_pwrdn;
  logic [5:0]  pll_refdiv;
  logic [7:0]  pll_mult_int;
  logic [15:0] pll_mult_frac;
  logic [3:0]  pll_outdiv;

  int checks = 0;
  int errors = 0;
  logic [15:0] r;

  localparam int Q = 3;

  always #2 clk = ~clk;

  pll_switch_seq #(.TICK_W(0)) u_pll_switch_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .lock_in(lock_in), .clk_sel_pll(clk_sel_pll), .pll_pwrdn(pll_pwrdn),
    .pll_refdiv(pll_refdiv), .pll_mult_int(pll_mult_int),
    .pll_mult_frac(pll_mult_frac), .pll_outdiv(pll_outdiv)
  );

  // {address, write data, expected read-back}
  localparam logic [34:0] VEC [8] = '{
    {3'd2, 16'hFFFF, 16'h003F},
    {3'd3, 16'h1234, 16'h0034},
    {3'd4, 16'hDCF9, 16'hDCF9},
    {3'd5, 16'h00A5, 16'h0005},
    {3'd6, 16'h0123, 16'h0123},
    {3'd7, 16'h0207, 16'h0007},
    {3'd0, 16'h0002, 16'h0000},
    {3'd3, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 sel", 16'(clk_sel_pll), 16'h0);
    chk("R1 pwrdn", 16'(pll_pwrdn), 16'h1);
    rd(3'd1, r); chk("R1 status", r, 16'h0000);
    rd(3'd2, r); chk("R1 refdiv", r, 16'h0001);
    rd(3'd6, r); chk("R1 timeout", r, 16'hFFFF);
    rd(3'd7, r); chk("R1 qualify", r, 16'h0004);

    // R2 register table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][34:32], VEC[i][31:16]);
      rd(VEC[i][34:32], r);
      chk("R2 readback", r, VEC[i][15:0]);
    end

    wr(3'd2, 16'h0001); wr(3'd3, 16'h000E); wr(3'd4, 16'hDCF9);
    wr(3'd5, 16'h0000); wr(3'd6, 16'd1000); wr(3'd7, 16'(Q));
    chk("R2 int port", 16'(pll_mult_int), 16'h000E);
    chk("R2 refdiv port", 16'(pll_refdiv), 16'h0001);
    chk("R2 frac port", pll_mult_frac, 16'hDCF9);
    chk("R2 outdiv port", 16'(pll_outdiv), 16'h0000);
    chk("R3 pwrdn off", 16'(pll_pwrdn), 16'h0);

    // R5 lock qualification timing
    wr(3'd0, 16'h0001);
    step(2);
    lock_in = 1'b1;
    step(Q + 2);
    chk("R5 sel early", 16'(clk_sel_pll), 16'h0);
    step(1);
    chk("R5 sel on", 16'(clk_sel_pll), 16'h1);
    rd(3'd1, r); chk("R5 status", r, 16'h0009);

    // R9 status write leaves select alone
    wr(3'd1, 16'h0006);
    chk("R9 sel kept", 16'(clk_sel_pll), 16'h1);

    // R8 loss of lock
    lock_in = 1'b0;
    step(2);
    chk("R8 sel hold", 16'(clk_sel_pll), 16'h1);
    step(1);
    chk("R8 sel drop", 16'(clk_sel_pll), 16'h0);
    rd(3'd1, r); chk("R8 lol flag", r, 16'h0002);
    wr(3'd1, 16'h0000);
    rd(3'd1, r); chk("R9 write0 keeps", r, 16'h0002);
    wr(3'd1, 16'h0002);
    rd(3'd1, r); chk("R9 w1c clears", r, 16'h0000);

    // Relock, then R4 settings write drops select
    lock_in = 1'b1;
    step(10);
    chk("R8 relock", 16'(clk_sel_pll), 16'h1);
    wr(3'd4, 16'h1111);
    chk("R4 sel drop", 16'(clk_sel_pll), 16'h0);
    chk("R2 frac update", pll_mult_frac, 16'h1111);

    // R6 steady lock must requalify
    step(Q + 2);
    chk("R6 sel early", 16'(clk_sel_pll), 16'h0);
    step(1);
    chk("R6 sel on", 16'(clk_sel_pll), 16'h1);

    // R3 power-down
    wr(3'd3, 16'h0000);
    chk("R3 pwrdn", 16'(pll_pwrdn), 16'h1);
    chk("R3 sel off", 16'(clk_sel_pll), 16'h0);
    step(20);
    chk("R3 sel stays", 16'(clk_sel_pll), 16'h0);
    wr(3'd3, 16'h000E);
    step(Q + 2);
    chk("R6 after pwrdn early", 16'(clk_sel_pll), 16'h0);
    step(1);
    chk("R6 after pwrdn on", 16'(clk_sel_pll), 16'h1);

    // R7 timeout with limit 5
    lock_in = 1'b0;
    wr(3'd6, 16'd5);
    step(7);
    rd(3'd1, r); chk("R7 before expiry", r & 16'h0004, 16'h0000);
    step(1);
    rd(3'd1, r); chk("R7 expiry", r & 16'h0004, 16'h0004);
    lock_in = 1'b1;
    step(20);
    chk("R7 stays xtal", 16'(clk_sel_pll), 16'h0);
    wr(3'd1, 16'h0004);
    rd(3'd1, r); chk("R9 tmo cleared", r & 16'h0004, 16'h0000);
    chk("R7 still xtal", 16'(clk_sel_pll), 16'h0);
    wr(3'd6, 16'd1000);
    step(Q + 3);
    chk("R7 exit relock", 16'(clk_sel_pll), 16'h1);

    // R10 enable cleared
    wr(3'd0, 16'h0000);
    chk("R10 sel off", 16'(clk_sel_pll), 16'h0);
    step(20);
    chk("R10 sel stays", 16'(clk_sel_pll), 16'h0);

    // R1 reset mid-run
    wr(3'd0, 16'h0001);
    step(Q + 3);
    chk("R1 pre-reset lock", 16'(clk_sel_pll), 16'h1);
    rst_n = 1'b0;
    step(1);
    chk("R1 reset sel", 16'(clk_sel_pll), 16'h0);
    rd(3'd1, r); chk("R1 reset status", r, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule